// File: doc/BRIEF.md
# Event Queue Ring Controller

This block keeps the bookkeeping for a small set of circular event queues that live in system memory. Every queue holds fixed-size 64-byte interrupt records. Hardware appends records at the tail. Software consumes them from the head and acknowledges them by writing a new head value. The controller stores, for each queue, a tail pointer that hardware advances, a head pointer that software writes, an enable bit and an overflow flag. From the enable bit and the overflow flag it derives a one-hot status code.

An upstream message-mapping stage raises a write request that names one queue. If that queue is enabled and has room, the controller produces a memory write strobe one cycle later. The address is the record slot at the old tail position: the base of the queue region, plus 8192 bytes per queue, plus 64 bytes per record. The tail then advances and wraps to zero after the configured entry count. While an enabled queue holds unacknowledged records, an interrupt-pending line stays high for that queue.

Software reaches the queues through a simple register port. Enabling and disabling use separate set and clear registers, so software never needs a read-modify-write. The overflow flag can be forced or cleared through the same pair of registers.

Top module: `evq_ring_ctrl`

## Requirements
- R1: After reset every queue is disabled, with head 0, tail 0, overflow 0 and status idle. All interrupt-pending lines and the memory write strobe are low.
- R2: Writing a 1 in bit 44 of a queue's set register enables the queue, and its status reads 3'b010 (active). Writing a 1 in bit 44 of its clear register disables it, and its status reads 3'b001 (idle). A write with bit 44 at 0 leaves the enable state unchanged.
- R3: Take a request for an enabled queue whose advanced tail would differ from its head. One cycle later it produces mem_we=1 with mem_addr = BASE + queue*8192 + old_tail*64. The tail becomes old_tail+1, or 0 when old_tail is ENTRIES-1.
- R4: Take a request for an enabled queue whose advanced tail equals its head (the queue is full). It produces no memory write and leaves the tail unchanged. It sets the overflow flag, and the status reads 3'b100 (error).
- R5: A request for a disabled queue produces no memory write, leaves the queue's pointers and overflow flag unchanged, and the status stays idle.
- R6: irq_pending[q] is high exactly when queue q is enabled and its head differs from its tail.
- R7: Writing the head register sets the head to write-data bits [6:0]. Reading it returns the head in bits [6:0], and acknowledged records stop counting as pending.
- R8: Bit 57 written as 1 to the set register forces overflow, and bit 57 written as 1 to the clear register clears it. The tail register reads the overflow flag in bit 57 and the tail in bits [6:0]. An enabled queue returns to active status when overflow is cleared.
- R9: reg_addr is {group[2:0], queue index}, with group 0 = set, 1 = clear, 2 = status, 3 = tail, 4 = head. Reads are combinational. Set and clear reads return enable in bit 44 and overflow in bit 57, status reads return the code in bits [2:0], and groups 5 to 7 read as zero.
- R10: When a register write and a request hit the same field of the same queue in one cycle, the register write wins. The request is still judged against the pointer values from before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | QW+3 | Register group and queue index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational register read data |
| ev_valid | input | 1 | Record write request |
| ev_queue | input | QW | Target queue of the request |
| mem_we | output | 1 | Registered memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the record slot |
| irq_pending | output | NQ | Per-queue unacknowledged-records indication |

## Verification
The embedded properties check, on every cycle, the following:
- A memory write only ever follows a request.
- A disabled queue never gets a memory write and never moves its tail.
- A request against a full queue always leaves overflow set.
- An accepted request always moves the tail.

Several behaviours can only be shown by the bench's sweeps over a four-queue, eight-entry configuration:
- The exact slot address of each record.
- Wrap-around after the last entry over several fill and drain rounds.
- The one-hot status codes.
- Register readback layout.
- The priority of a register write over a request in the same cycle.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int PTR_W   = 7;
    localparam int EN_BIT  = 44;
    localparam int OVF_BIT = 57;

    typedef enum logic [2:0] {
        GRP_SET   = 3'd0,
        GRP_CLR   = 3'd1,
        GRP_STAT  = 3'd2,
        GRP_TAIL  = 3'd3,
        GRP_HEAD  = 3'd4
    } grp_e;

    localparam logic [2:0] ST_IDLE = 3'b001;
    localparam logic [2:0] ST_ACT  = 3'b010;
    localparam logic [2:0] ST_ERR  = 3'b100;

    typedef struct packed {
        logic             en;
        logic             ovf;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } qstate_t;
endpackage

// File: rtl/evq_regdec.sv
module evq_regdec #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic          reg_wr,
    input  logic [QW+2:0] reg_addr,
    input  logic [63:0]   reg_wdata,
    output logic [NQ-1:0] set_en,
    output logic [NQ-1:0] clr_en,
    output logic [NQ-1:0] set_ovf,
    output logic [NQ-1:0] clr_ovf,
    output logic [NQ-1:0] head_wr,
    output logic [NQ-1:0] tail_wr
);
    import evq_pkg::*;

    logic [2:0]    grp;
    logic [QW-1:0] qsel;

    assign grp  = reg_addr[QW+2:QW];
    assign qsel = reg_addr[QW-1:0];

    for (genvar i = 0; i < NQ; i++) begin : g_dec
        logic hit;
        assign hit        = reg_wr && (qsel == QW'(i));
        assign set_en[i]  = hit && (grp == GRP_SET)  && reg_wdata[EN_BIT];
        assign clr_en[i]  = hit && (grp == GRP_CLR)  && reg_wdata[EN_BIT];
        assign set_ovf[i] = hit && (grp == GRP_SET)  && reg_wdata[OVF_BIT];
        assign clr_ovf[i] = hit && (grp == GRP_CLR)  && reg_wdata[OVF_BIT];
        assign head_wr[i] = hit && (grp == GRP_HEAD);
        assign tail_wr[i] = hit && (grp == GRP_TAIL);
    end
endmodule

// File: rtl/evq_queue.sv
module evq_queue #(
    parameter int ENTRIES = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_req,
    input  logic                      set_en,
    input  logic                      clr_en,
    input  logic                      set_ovf,
    input  logic                      clr_ovf,
    input  logic                      head_wr,
    input  logic                      tail_wr,
    input  logic [evq_pkg::PTR_W-1:0] wptr,
    output logic                      en,
    output logic                      ovf,
    output logic [evq_pkg::PTR_W-1:0] head,
    output logic [evq_pkg::PTR_W-1:0] tail,
    output logic                      accept,
    output logic [2:0]                state,
    output logic                      pending
);
    import evq_pkg::*;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    qstate_t          s_q, s_d;
    logic [PTR_W-1:0] nxt_tail;
    logic             full;
    logic             drop_full;

    always_comb begin
        nxt_tail  = (s_q.tail == LAST) ? '0 : s_q.tail + 1'b1;
        full      = (nxt_tail == s_q.head);
        accept    = ev_req && s_q.en && !full;
        drop_full = ev_req && s_q.en && full;

        s_d = s_q;
        if (accept)    s_d.tail = nxt_tail;
        if (drop_full) s_d.ovf  = 1'b1;
        if (set_en)    s_d.en   = 1'b1;
        if (clr_en)    s_d.en   = 1'b0;
        if (set_ovf)   s_d.ovf  = 1'b1;
        if (clr_ovf)   s_d.ovf  = 1'b0;
        if (head_wr)   s_d.head = wptr;
        if (tail_wr)   s_d.tail = wptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en      = s_q.en;
    assign ovf     = s_q.ovf;
    assign head    = s_q.head;
    assign tail    = s_q.tail;
    assign state   = !s_q.en ? ST_IDLE : (s_q.ovf ? ST_ERR : ST_ACT);
    assign pending = s_q.en && (s_q.head != s_q.tail);

    // R5: a disabled queue keeps its tail unless software writes it
    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en && !tail_wr) |=> (s_q.tail == $past(s_q.tail)));

    // R4: a request against a full queue leaves overflow set
    p_full_sets_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req && s_q.en && full && !clr_ovf) |=> s_q.ovf);

    // R3: an accepted record always moves the tail
    p_accept_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tail_wr) |=> (s_q.tail != $past(s_q.tail)));
endmodule

// File: rtl/evq_wraddr.sv
module evq_wraddr #(
    parameter int          ADDR_W  = 48,
    parameter logic [47:0] BASE    = 48'h0,
    parameter int          QW      = 2,
    parameter int          REC_SH  = 6,
    parameter int          Q_SH    = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [QW-1:0]             qidx,
    input  logic [evq_pkg::PTR_W-1:0] tail,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr
);
    logic              we_d, we_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        we_d   = accept;
        addr_d = addr_q;
        if (accept)
            addr_d = ADDR_W'(BASE) + (ADDR_W'(qidx) << Q_SH) + (ADDR_W'(tail) << REC_SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            we_q   <= we_d;
            addr_q <= addr_d;
        end
    end

    assign mem_we   = we_q;
    assign mem_addr = addr_q;
endmodule

// File: rtl/evq_ring_ctrl.sv
module evq_ring_ctrl #(
    parameter int          NQ          = 4,
    parameter int          ENTRIES     = 128,
    parameter int          ADDR_W      = 48,
    parameter logic [47:0] BASE        = 48'h0000_8000_0000,
    parameter int          REC_BYTES   = 64,
    parameter int          QUEUE_BYTES = 8192,
    localparam int         QW          = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [QW+2:0]     reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              ev_valid,
    input  logic [QW-1:0]     ev_queue,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NQ-1:0]     irq_pending
);
    import evq_pkg::*;

    localparam int REC_SH = $clog2(REC_BYTES);
    localparam int Q_SH   = $clog2(QUEUE_BYTES);

    logic [NQ-1:0]    set_en, clr_en, set_ovf, clr_ovf, head_wr, tail_wr;
    logic [NQ-1:0]    en_v, ovf_v, acc_v, req_v;
    logic [PTR_W-1:0] head_v [NQ];
    logic [PTR_W-1:0] tail_v [NQ];
    logic [2:0]       state_v [NQ];

    evq_regdec #(.NQ(NQ), .QW(QW)) u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .set_en   (set_en),
        .clr_en   (clr_en),
        .set_ovf  (set_ovf),
        .clr_ovf  (clr_ovf),
        .head_wr  (head_wr),
        .tail_wr  (tail_wr)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_q
        assign req_v[i] = ev_valid && (ev_queue == QW'(i));
        evq_queue #(.ENTRIES(ENTRIES)) u_q (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_req (req_v[i]),
            .set_en (set_en[i]),
            .clr_en (clr_en[i]),
            .set_ovf(set_ovf[i]),
            .clr_ovf(clr_ovf[i]),
            .head_wr(head_wr[i]),
            .tail_wr(tail_wr[i]),
            .wptr   (reg_wdata[PTR_W-1:0]),
            .en     (en_v[i]),
            .ovf    (ovf_v[i]),
            .head   (head_v[i]),
            .tail   (tail_v[i]),
            .accept (acc_v[i]),
            .state  (state_v[i]),
            .pending(irq_pending[i])
        );
    end

    evq_wraddr #(
        .ADDR_W(ADDR_W), .BASE(BASE), .QW(QW), .REC_SH(REC_SH), .Q_SH(Q_SH)
    ) u_wa (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (acc_v[ev_queue]),
        .qidx    (ev_queue),
        .tail    (tail_v[ev_queue]),
        .mem_we  (mem_we),
        .mem_addr(mem_addr)
    );

    logic [2:0]    rgrp;
    logic [QW-1:0] rq;
    assign rgrp = reg_addr[QW+2:QW];
    assign rq   = reg_addr[QW-1:0];

    always_comb begin
        reg_rdata = '0;
        case (rgrp)
            GRP_SET, GRP_CLR: begin
                reg_rdata[EN_BIT]  = en_v[rq];
                reg_rdata[OVF_BIT] = ovf_v[rq];
            end
            GRP_STAT: reg_rdata[2:0] = state_v[rq];
            GRP_TAIL: begin
                reg_rdata[PTR_W-1:0] = tail_v[rq];
                reg_rdata[OVF_BIT]   = ovf_v[rq];
            end
            GRP_HEAD: reg_rdata[PTR_W-1:0] = head_v[rq];
            default:  reg_rdata = '0;
        endcase
    end

    // R3: a memory write only follows a request
    p_we_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(ev_valid));

    // R5: a request to a disabled queue writes nothing
    p_no_write_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !en_v[ev_queue]) |=> !mem_we);
endmodule

// File: tb/evq_ring_ctrl_tb.sv
`timescale 1ns/1ps
module evq_ring_ctrl_tb_top;
    localparam int          NQ   = 4;
    localparam int          ENT  = 8;
    localparam int          AW   = 48;
    localparam logic [47:0] BASE = 48'h0000_4000_0000;
    localparam int          QW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [QW+2:0]   reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            ev_valid = 1'b0;
    logic [QW-1:0]   ev_queue = '0;
    logic            mem_we;
    logic [AW-1:0]   mem_addr;
    logic [NQ-1:0]   irq_pending;

    int n_run = 0;
    int n_fail = 0;
    int m_head [NQ];
    int m_tail [NQ];

    always #4 clk = ~clk;

    evq_ring_ctrl #(.NQ(NQ), .ENTRIES(ENT), .ADDR_W(AW), .BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_queue(ev_queue), .mem_we(mem_we), .mem_addr(mem_addr),
        .irq_pending(irq_pending)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int grp, input int q, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {3'(grp), QW'(q)}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int grp, input int q, output logic [63:0] v);
        reg_addr = {3'(grp), QW'(q)};
        #1 v = reg_rdata;
    endtask

    function automatic logic [47:0] slot(input int q, input int t);
        return BASE + 48'(q) * 48'd8192 + 48'(t) * 48'd64;
    endfunction

    // push one request; expect accept when 'acc'
    task automatic push(input int q, input bit acc, input string req);
        @(negedge clk);
        ev_valid = 1'b1; ev_queue = QW'(q);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(req, 64'(mem_we), 64'(acc));
        if (acc) begin
            chk(req, 64'(mem_addr), 64'(slot(q, m_tail[q])));
            m_tail[q] = (m_tail[q] + 1) % ENT;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        for (int q = 0; q < NQ; q++) begin m_head[q] = 0; m_tail[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 64'(irq_pending), 64'd0);
        chk("R1 we", 64'(mem_we), 64'd0);
        for (int q = 0; q < NQ; q++) begin
            rd(2, q, v); chk("R1 state", v, 64'd1);
            rd(3, q, v); chk("R1 tail", v, 64'd0);
            rd(4, q, v); chk("R1 head", v, 64'd0);
        end

        // R5 disabled queue drops request
        push(0, 1'b0, "R5 drop");
        rd(3, 0, v); chk("R5 tail", v, 64'd0);
        rd(2, 0, v); chk("R5 state", v, 64'd1);

        // R2 write without bit 44 has no effect
        wr(0, 0, 64'h1);
        rd(2, 0, v); chk("R2 no-op", v, 64'd1);
        for (int q = 0; q < NQ; q++) begin
            wr(0, q, 64'd1 << 44);
            rd(2, q, v); chk("R2 active", v, 64'd2);
            rd(0, q, v); chk("R9 set readback", v, 64'd1 << 44);
        end
        rd(5, 0, v); chk("R9 empty group", v, 64'd0);

        // R3 fill each queue, R4 overflow, R8 clear, R7 ack
        for (int q = 0; q < NQ; q++) begin
            for (int k = 0; k < ENT - 1; k++) push(q, 1'b1, "R3 fill");
            rd(3, q, v); chk("R3 tail", v, 64'(m_tail[q]));
            chk("R6 pending", 64'(irq_pending[q]), 64'd1);
            push(q, 1'b0, "R4 full");
            rd(3, q, v); chk("R4 R8 tail+ovf", v, (64'd1 << 57) | 64'(m_tail[q]));
            rd(2, q, v); chk("R4 error", v, 64'd4);
            wr(1, q, 64'd1 << 57);
            rd(2, q, v); chk("R8 cleared", v, 64'd2);
            wr(4, q, 64'(m_tail[q])); m_head[q] = m_tail[q];
            rd(4, q, v); chk("R7 head", v, 64'(m_head[q]));
            chk("R6 R7 acked", 64'(irq_pending[q]), 64'd0);
        end

        // R3 wrap sweep on queue 1
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 5; k++) push(1, 1'b1, "R3 wrap");
            rd(3, 1, v); chk("R3 wrap tail", v, 64'(m_tail[1]));
            wr(4, 1, 64'(m_tail[1])); m_head[1] = m_tail[1];
        end

        // R8 forced overflow
        wr(0, 0, 64'd1 << 57);
        rd(2, 0, v); chk("R8 forced", v, 64'd4);
        wr(1, 0, 64'd1 << 57);
        rd(2, 0, v); chk("R8 forced clr", v, 64'd2);

        // R2/R5/R6 disable queue 2 with a pending record
        push(2, 1'b1, "R3 one");
        chk("R6 q2 pending", 64'(irq_pending[2]), 64'd1);
        wr(1, 2, 64'd1 << 44);
        rd(2, 2, v); chk("R2 idle", v, 64'd1);
        chk("R6 disabled", 64'(irq_pending[2]), 64'd0);
        push(2, 1'b0, "R5 disabled drop");
        rd(3, 2, v); chk("R5 kept tail", v, 64'(m_tail[2]));

        // R10 tail write and request in the same cycle on queue 3
        @(negedge clk);
        ev_valid = 1'b1; ev_queue = 2'd3;
        reg_wr = 1'b1; reg_addr = {3'd3, 2'd3}; reg_wdata = 64'd2;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk("R10 we", 64'(mem_we), 64'd1);
        chk("R10 addr", 64'(mem_addr), 64'(slot(3, m_tail[3])));
        rd(3, 3, v); chk("R10 tail wins", v, 64'd2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule